// File: doc/BRIEF.md
# Egress Page-Chain Transfer Engine

This block is the transmit side of one switch port. A shared command bus carries transmit commands. Each command holds a destination mask and the pointer to the first page of a stored frame. The engine accepts only the commands whose mask includes its own port. It keeps their first-page pointers in a small start queue, so frames leave in the order they were accepted. For each frame it reads the page header, moves that page's payload bytes to the transmit byte FIFO, and follows the header's link to the next page. It stops at the page whose header is flagged as final.

Pages that have been sent go back to the free pool through a small release FIFO. How this happens depends on the number of destinations. A frame with one destination has each page released as soon as its payload has been read. A frame with several destinations keeps its pages until every destination has finished. Each engine keeps a copy of a remaining-destination count for every page. The count is loaded from the mask's population count when the command is accepted. It is decremented for each completion announced on a shared done bus. When the engine finishes a frame, it asks for a done-bus slot. If the count is one when the slot is granted, this engine is the last finisher. It then walks the chain's headers a second time and releases every page.

Top module: `egress_chain_dma`

## Requirements
- R1: After reset, cmdReady is 1 and txValid, relValid, memReq and doneReq are all 0.
- R2: A command whose mask has bit PORT_ID clear causes no memory read, no transmitted byte and no release.
- R3: A page's header is word 0 of that page, where the memory word address is {page, offset}. The header holds the next-page pointer in bits [PW-1:0], a byte count in bits [PW+OW-1:PW], and the final-page flag in bit PW+OW. Payload bytes are the low 8 bits of words 1, 2 and onward. They are sent in chain order, with at most one memory read outstanding at a time.
- R4: A page that is not final sends PAGE_WORDS-1 bytes. The final page sends only as many bytes as its header's count field gives.
- R5: For a frame with one destination, each page pointer appears on the release output in chain order. It appears after that page's last byte and before any byte of the next page.
- R6: For a frame with several destinations, no page is released during the transfer. After the last byte, doneReq rises with donePage equal to the first page, and stays high until doneGrant.
- R7: If the remaining-destination count of the first page is above one when doneGrant arrives, the engine releases nothing and returns to idle.
- R8: If that count is exactly one at the grant, the engine re-reads the chain's headers and releases every page of the frame in chain order.
- R9: cmdReady goes low only when a valid command's mask includes this port while the start queue is full. Such a command is held, not lost, and is accepted once there is room.
- R10: Frames are transmitted in the order their commands were accepted.
- R11: While txValid is high and txReady is low, txValid stays high and txByte stays unchanged.
- R12: While relValid is high and relReady is low, relValid stays high and relPage stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command on the shared bus |
| cmdDestMask | input | NPORTS | Destination port mask of the command |
| cmdPage | input | PW | First page pointer of the frame |
| cmdReady | output | 1 | Low to hold a command this port cannot queue |
| cmdGo | input | 1 | Bus-wide acceptance of the current command |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | PW+OW | Word address {page, offset} |
| memValid | input | 1 | Read data valid |
| memData | input | MW | Read data |
| txValid | output | 1 | Byte offered to the transmit FIFO |
| txByte | output | 8 | Byte to transmit |
| txReady | input | 1 | Transmit FIFO can take a byte |
| doneReq | output | 1 | Request to announce a finished multi-destination frame |
| donePage | output | PW | First page of the finished frame |
| doneGrant | input | 1 | This port's announcement is on the done bus this cycle |
| busDoneValid | input | 1 | Done bus carries an announcement from any port |
| busDonePage | input | PW | First page named on the done bus |
| relValid | output | 1 | Page pointer ready to return to the pool |
| relPage | output | PW | Released page pointer |
| relReady | input | 1 | Pool takes the released pointer |

## Verification
The bench builds chains that end on a partly filled page and on a full one. A length check tied to the wrong header field, or an off-by-one offset limit, would drop or repeat the final bytes. Multi-destination frames are finished with the remaining count both above one and at one. An engine that releases too early, or treats every finisher as last, would return shared pages twice or never. The start queue is filled while the transmit FIFO is stalled. A design that drops the extra command, or stalls commands meant for other ports, would lose a frame or block the whole bus. Irregular ready patterns on the transmit and release sides show whether a held byte or pointer changes before it is taken.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

  // Strobes from the sequencer into the datapath
  typedef struct packed {
    logic sqPop;     // take head of start queue as current frame
    logic ldHdr;     // capture header fields from read data
    logic clrOff;    // point at first payload word
    logic incOff;    // advance payload word
    logic ldData;    // capture payload byte
    logic selNext;   // follow link to next page
    logic selFirst;  // rewind to first page of the frame
    logic pushFree;  // queue current page for release
    logic addrHdr;   // address word 0 of current page
  } ecdStrobes_t;

  // Conditions reported back to the sequencer
  typedef struct packed {
    logic sqEmpty;
    logic multi;
    logic lastPg;
    logic offAtLimit;
    logic freeFull;
    logic rcIsOne;
  } ecdStatus_t;

  function automatic int unsigned popCount(input logic [31:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 32; i++) c += 32'(v[i]);
    return c;
  endfunction

endpackage

// File: rtl/ecd_datapath.sv
module ecd_datapath
  import ecd_pkg::*;
#(
  parameter int PORT_ID    = 1,
  parameter int NPORTS     = 4,
  parameter int PW         = 6,
  parameter int PAGE_WORDS = 8,
  parameter int SQ_DEPTH   = 4,
  parameter int FREE_DEPTH = 4,
  parameter int MW         = 16,
  localparam int OW        = $clog2(PAGE_WORDS),
  localparam int AW        = PW + OW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ecdStrobes_t       st,
  input  logic              cmdValid,
  input  logic [NPORTS-1:0] cmdDestMask,
  input  logic [PW-1:0]     cmdPage,
  input  logic              cmdGo,
  output logic              cmdReady,
  output logic [AW-1:0]     memAddr,
  input  logic [MW-1:0]     memData,
  output logic [7:0]        txByte,
  output logic [PW-1:0]     donePage,
  input  logic              busDoneValid,
  input  logic [PW-1:0]     busDonePage,
  output logic              relValid,
  output logic [PW-1:0]     relPage,
  input  logic              relReady,
  output ecdStatus_t        stat
);
  localparam int SQW       = $clog2(SQ_DEPTH);
  localparam int FRW       = $clog2(FREE_DEPTH);
  localparam int RCW       = $clog2(NPORTS + 1);
  localparam int NPAGES    = 1 << PW;
  localparam int PAGE_DATA = PAGE_WORDS - 1;

  // ---------------- start-address queue ----------------
  logic [PW-1:0]  sqPage  [SQ_DEPTH];
  logic           sqMulti [SQ_DEPTH];
  logic [SQW-1:0] sqWr, sqRd;
  logic [SQW:0]   sqCnt;
  logic           forUs, sqFull, sqPush;
  logic [RCW-1:0] destCnt;

  assign forUs    = cmdDestMask[PORT_ID];
  assign sqFull   = (sqCnt == (SQW+1)'(SQ_DEPTH));
  assign cmdReady = !(cmdValid && forUs && sqFull);
  assign sqPush   = cmdValid && cmdGo && forUs && !sqFull;
  assign destCnt  = RCW'(popCount(32'(cmdDestMask)));

  always_ff @(posedge clk) begin
    if (sqPush) begin
      sqPage[sqWr]  <= cmdPage;
      sqMulti[sqWr] <= (destCnt > RCW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sqWr  <= '0;
      sqRd  <= '0;
      sqCnt <= '0;
    end else begin
      if (sqPush)   sqWr <= sqWr + SQW'(1);
      if (st.sqPop) sqRd <= sqRd + SQW'(1);
      sqCnt <= sqCnt + (SQW+1)'(sqPush) - (SQW+1)'(st.sqPop);
    end
  end

  // ---------------- page walk registers ----------------
  logic [PW-1:0] curPage, firstPage, nextReg;
  logic [OW-1:0] off, cntReg;
  logic          lastReg, multiReg;
  logic [7:0]    dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage   <= '0;
      firstPage <= '0;
      multiReg  <= 1'b0;
      nextReg   <= '0;
      cntReg    <= '0;
      lastReg   <= 1'b0;
      off       <= '0;
      dataReg   <= '0;
    end else begin
      if (st.sqPop) begin
        curPage   <= sqPage[sqRd];
        firstPage <= sqPage[sqRd];
        multiReg  <= sqMulti[sqRd];
      end else if (st.selNext) begin
        curPage <= nextReg;
      end else if (st.selFirst) begin
        curPage <= firstPage;
      end
      if (st.ldHdr) begin
        nextReg <= memData[PW-1:0];
        cntReg  <= memData[PW+OW-1:PW];
        lastReg <= memData[PW+OW];
      end
      if (st.clrOff)      off <= OW'(1);
      else if (st.incOff) off <= off + OW'(1);
      if (st.ldData) dataReg <= memData[7:0];
    end
  end

  assign memAddr  = {curPage, (st.addrHdr ? OW'(0) : off)};
  assign txByte   = dataReg;
  assign donePage = firstPage;

  // ---------------- release FIFO ----------------
  logic [PW-1:0]  frPage [FREE_DEPTH];
  logic [FRW-1:0] frWr, frRd;
  logic [FRW:0]   frCnt;
  logic           frFull, frPop;

  assign frFull   = (frCnt == (FRW+1)'(FREE_DEPTH));
  assign relValid = (frCnt != '0);
  assign relPage  = frPage[frRd];
  assign frPop    = relValid && relReady;

  always_ff @(posedge clk) begin
    if (st.pushFree) frPage[frWr] <= curPage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frWr  <= '0;
      frRd  <= '0;
      frCnt <= '0;
    end else begin
      if (st.pushFree) frWr <= frWr + FRW'(1);
      if (frPop)       frRd <= frRd + FRW'(1);
      frCnt <= frCnt + (FRW+1)'(st.pushFree) - (FRW+1)'(frPop);
    end
  end

  // ---------------- remaining-destination counts ----------------
  logic [RCW-1:0] rc [NPAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPAGES; i++) rc[i] <= '0;
    end else begin
      if (sqPush) rc[cmdPage] <= destCnt;
      if (busDoneValid && rc[busDonePage] != '0 && !(sqPush && cmdPage == busDonePage))
        rc[busDonePage] <= rc[busDonePage] - RCW'(1);
    end
  end

  assign stat.sqEmpty    = (sqCnt == '0);
  assign stat.multi      = multiReg;
  assign stat.lastPg     = lastReg;
  assign stat.offAtLimit = (off == (lastReg ? cntReg : OW'(PAGE_DATA)));
  assign stat.freeFull   = frFull;
  assign stat.rcIsOne    = (rc[firstPage] == RCW'(1));

  // R5
  free_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.pushFree |-> (frCnt < (FRW+1)'(FREE_DEPTH)));

  // R12
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    relValid && !relReady |=> relValid && $stable(relPage));

endmodule

// File: rtl/ecd_control.sv
module ecd_control
  import ecd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ecdStatus_t  stat,
  input  logic        memValid,
  input  logic        txReady,
  input  logic        doneGrant,
  output ecdStrobes_t st,
  output logic        memReq,
  output logic        txValid,
  output logic        doneReq
);
  typedef enum logic [3:0] {
    S_IDLE, S_HDR_REQ, S_HDR_WAIT, S_DAT_REQ, S_DAT_WAIT, S_DAT_SEND,
    S_PAGE_END, S_DONE, S_REL_REQ, S_REL_WAIT, S_REL_PUSH
  } ecdState_t;

  ecdState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    st        = '0;
    memReq    = 1'b0;
    txValid   = 1'b0;
    doneReq   = 1'b0;
    unique case (state)
      S_IDLE: if (!stat.sqEmpty) begin
        st.sqPop  = 1'b1;
        nextState = S_HDR_REQ;
      end
      S_HDR_REQ: begin
        memReq     = 1'b1;
        st.addrHdr = 1'b1;
        nextState  = S_HDR_WAIT;
      end
      S_HDR_WAIT: if (memValid) begin
        st.ldHdr  = 1'b1;
        st.clrOff = 1'b1;
        nextState = S_DAT_REQ;
      end
      S_DAT_REQ: begin
        memReq    = 1'b1;
        nextState = S_DAT_WAIT;
      end
      S_DAT_WAIT: if (memValid) begin
        st.ldData = 1'b1;
        nextState = S_DAT_SEND;
      end
      S_DAT_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          if (stat.offAtLimit) nextState = S_PAGE_END;
          else begin
            st.incOff = 1'b1;
            nextState = S_DAT_REQ;
          end
        end
      end
      S_PAGE_END: begin
        if (stat.multi) begin
          if (stat.lastPg) nextState = S_DONE;
          else begin
            st.selNext = 1'b1;
            nextState  = S_HDR_REQ;
          end
        end else if (!stat.freeFull) begin
          st.pushFree = 1'b1;
          if (stat.lastPg) nextState = S_IDLE;
          else begin
            st.selNext = 1'b1;
            nextState  = S_HDR_REQ;
          end
        end
      end
      S_DONE: begin
        doneReq = 1'b1;
        if (doneGrant) begin
          if (stat.rcIsOne) begin
            st.selFirst = 1'b1;
            nextState   = S_REL_REQ;
          end else nextState = S_IDLE;
        end
      end
      S_REL_REQ: begin
        memReq     = 1'b1;
        st.addrHdr = 1'b1;
        nextState  = S_REL_WAIT;
      end
      S_REL_WAIT: if (memValid) begin
        st.ldHdr  = 1'b1;
        nextState = S_REL_PUSH;
      end
      S_REL_PUSH: if (!stat.freeFull) begin
        st.pushFree = 1'b1;
        if (stat.lastPg) nextState = S_IDLE;
        else begin
          st.selNext = 1'b1;
          nextState  = S_REL_REQ;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneReq && !doneGrant |=> doneReq);

endmodule

// File: rtl/egress_chain_dma.sv
module egress_chain_dma
  import ecd_pkg::*;
#(
  parameter int PORT_ID    = 1,
  parameter int NPORTS     = 4,
  parameter int PW         = 6,
  parameter int PAGE_WORDS = 8,
  parameter int SQ_DEPTH   = 4,
  parameter int FREE_DEPTH = 4,
  parameter int MW         = 16,
  localparam int OW        = $clog2(PAGE_WORDS),
  localparam int AW        = PW + OW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [NPORTS-1:0] cmdDestMask,
  input  logic [PW-1:0]     cmdPage,
  output logic              cmdReady,
  input  logic              cmdGo,
  output logic              memReq,
  output logic [AW-1:0]     memAddr,
  input  logic              memValid,
  input  logic [MW-1:0]     memData,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txReady,
  output logic              doneReq,
  output logic [PW-1:0]     donePage,
  input  logic              doneGrant,
  input  logic              busDoneValid,
  input  logic [PW-1:0]     busDonePage,
  output logic              relValid,
  output logic [PW-1:0]     relPage,
  input  logic              relReady
);
  ecdStrobes_t st;
  ecdStatus_t  stat;

  ecd_control u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .memValid(memValid),
    .txReady(txReady), .doneGrant(doneGrant), .st(st),
    .memReq(memReq), .txValid(txValid), .doneReq(doneReq)
  );

  ecd_datapath #(
    .PORT_ID(PORT_ID), .NPORTS(NPORTS), .PW(PW), .PAGE_WORDS(PAGE_WORDS),
    .SQ_DEPTH(SQ_DEPTH), .FREE_DEPTH(FREE_DEPTH), .MW(MW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .cmdValid(cmdValid), .cmdDestMask(cmdDestMask), .cmdPage(cmdPage),
    .cmdGo(cmdGo), .cmdReady(cmdReady),
    .memAddr(memAddr), .memData(memData), .txByte(txByte),
    .donePage(donePage), .busDoneValid(busDoneValid), .busDonePage(busDonePage),
    .relValid(relValid), .relPage(relPage), .relReady(relReady), .stat(stat)
  );

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte));

endmodule

// File: tb/tb_egress_chain_dma.sv
module tb_egress_chain_dma;
  localparam int PW = 6;
  localparam int OW = 3;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [NP-1:0] cmdDestMask = '0;
  logic [PW-1:0] cmdPage = '0;
  logic          cmdReady, cmdGo;
  logic          memReq;
  logic [PW+OW-1:0] memAddr;
  logic          memValid = 1'b0;
  logic [15:0]   memData = '0;
  logic          txValid;
  logic [7:0]    txByte;
  logic          txReady = 1'b1;
  logic          doneReq;
  logic [PW-1:0] donePage;
  logic          doneGrant = 1'b0;
  logic          peerV = 1'b0;
  logic [PW-1:0] peerPage = '0;
  logic          busDoneValid;
  logic [PW-1:0] busDonePage;
  logic          relValid;
  logic [PW-1:0] relPage;
  logic          relReady = 1'b1;

  assign cmdGo        = cmdReady;
  assign busDoneValid = peerV | (doneReq & doneGrant);
  assign busDonePage  = peerV ? peerPage : donePage;

  egress_chain_dma dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdDestMask(cmdDestMask),
    .cmdPage(cmdPage), .cmdReady(cmdReady), .cmdGo(cmdGo),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .txValid(txValid), .txByte(txByte), .txReady(txReady),
    .doneReq(doneReq), .donePage(donePage), .doneGrant(doneGrant),
    .busDoneValid(busDoneValid), .busDonePage(busDonePage),
    .relValid(relValid), .relPage(relPage), .relReady(relReady)
  );

  always #4 clk = ~clk;  // 125 MHz

  int compared = 0;
  int mismatched = 0;

  // memory model, one cycle read latency
  logic [15:0] mem [512];
  always @(posedge clk) begin
    memValid <= memReq;
    memData  <= mem[memAddr];
  end

  // monitors
  logic [7:0] txLog [512];
  int txN = 0;
  int relLog [128];
  int relAtTx [128];
  int relN = 0;
  int memReqN = 0;
  logic holdPend = 1'b0;
  logic [7:0] holdByte = '0;
  logic relPend = 1'b0;
  logic [PW-1:0] relHeld = '0;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      if (holdPend) check("R11 held byte", (txValid && txByte == holdByte) ? 1 : 0, 1);
      holdPend <= txValid && !txReady;
      holdByte <= txByte;
      if (relPend) check("R12 held release", (relValid && relPage == relHeld) ? 1 : 0, 1);
      relPend <= relValid && !relReady;
      relHeld <= relPage;
      if (memReq) memReqN++;
      if (relValid && relReady) begin
        relLog[relN]  = int'(relPage);
        relAtTx[relN] = txN;
        relN++;
      end
      if (txValid && txReady) begin
        txLog[txN] = txByte;
        txN++;
      end
    end
  end

  function automatic int byteOf(input int page, input int off);
    return (page * 8 + off) & 255;
  endfunction

  // header: next in [5:0], count in [8:6], final flag in [9]
  task automatic setPage(input int page, input int nxt, input bit fin, input int cnt);
    mem[page*8] = 16'((int'(fin) << 9) | (cnt << 6) | nxt);
    for (int o = 1; o < 8; o++) mem[page*8 + o] = 16'(byteOf(page, o));
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [NP-1:0] m, input int page);
    @(negedge clk);
    cmdValid = 1'b1; cmdDestMask = m; cmdPage = PW'(page);
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdDestMask = '0;
  endtask

  task automatic peerDone(input int page);
    @(negedge clk); peerV = 1'b1; peerPage = PW'(page);
    @(negedge clk); peerV = 1'b0;
  endtask

  task automatic grantOnce();
    @(negedge clk); doneGrant = 1'b1;
    @(negedge clk); doneGrant = 1'b0;
  endtask

  // compare bytes of a chain starting at log index base
  task automatic checkChain(input string req, input int base, input int pg [3],
                            input int n, input int lastCnt);
    int idx = base;
    for (int p = 0; p < n; p++) begin
      int lim = (p == n - 1) ? lastCnt : 7;
      for (int o = 1; o <= lim; o++) begin
        check(req, int'(txLog[idx]), byteOf(pg[p], o));
        idx++;
      end
    end
    check({req, " byte count"}, txN - base, idx - base);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 cmdReady", int'(cmdReady), 1);
    check("R1 txValid", int'(txValid), 0);
    check("R1 relValid", int'(relValid), 0);
    check("R1 memReq", int'(memReq), 0);
    check("R1 doneReq", int'(doneReq), 0);
  endtask

  task automatic testFilter();
    int m0 = memReqN;
    int t0 = txN;
    int r0 = relN;
    setPage(2, 0, 1, 3);
    sendCmd(4'b1101, 2);
    waitCyc(30);
    check("R2 no reads", memReqN - m0, 0);
    check("R2 no bytes", txN - t0, 0);
    check("R2 no release", relN - r0, 0);
  endtask

  task automatic testSingle();
    int base = txN;
    int r0 = relN;
    int pg [3] = '{5, 9, 3};
    setPage(5, 9, 0, 2);
    setPage(9, 3, 0, 1);
    setPage(3, 0, 1, 4);
    sendCmd(4'b0010, 5);
    waitCyc(120);
    checkChain("R3 R4 chain bytes", base, pg, 3, 4);
    check("R5 release count", relN - r0, 3);
    for (int i = 0; i < 3; i++) begin
      check("R5 release order", relLog[r0 + i], pg[i]);
      check("R5 release timing", relAtTx[r0 + i] - base, (i == 2) ? 18 : 7 * (i + 1));
    end
  endtask

  task automatic testMultiNotLast();
    int base = txN;
    int r0 = relN;
    int pg [3] = '{12, 20, 0};
    setPage(12, 20, 0, 0);
    setPage(20, 0, 1, 2);
    sendCmd(4'b0111, 12);
    waitCyc(120);
    checkChain("R6 multi bytes", base, pg, 2, 2);
    check("R6 no early release", relN - r0, 0);
    check("R6 doneReq", int'(doneReq), 1);
    check("R6 donePage", int'(donePage), 12);
    peerDone(12);
    check("R6 doneReq held", int'(doneReq), 1);
    grantOnce();
    waitCyc(30);
    check("R7 doneReq cleared", int'(doneReq), 0);
    check("R7 nothing released", relN - r0, 0);
  endtask

  task automatic testMultiLast();
    int base = txN;
    int r0 = relN;
    int pg [3] = '{30, 31, 40};
    setPage(30, 31, 0, 0);
    setPage(31, 40, 0, 0);
    setPage(40, 0, 1, 7);
    sendCmd(4'b0011, 30);
    waitCyc(150);
    checkChain("R4 full final page", base, pg, 3, 7);
    check("R6 no early release", relN - r0, 0);
    check("R6 donePage", int'(donePage), 30);
    peerDone(30);
    grantOnce();
    waitCyc(40);
    check("R8 release count", relN - r0, 3);
    for (int i = 0; i < 3; i++) check("R8 release order", relLog[r0 + i], pg[i]);
    check("R8 doneReq cleared", int'(doneReq), 0);
  endtask

  task automatic testBackPressure();
    int base = txN;
    @(negedge clk); txReady = 1'b0;
    for (int p = 50; p < 56; p++) setPage(p, 0, 1, 1);
    for (int p = 50; p < 55; p++) sendCmd(4'b0010, p);
    @(negedge clk);
    cmdValid = 1'b1; cmdDestMask = 4'b0010; cmdPage = PW'(55);
    #1;
    check("R9 held when full", int'(cmdReady), 0);
    cmdDestMask = 4'b0100;
    #1;
    check("R9 others not held", int'(cmdReady), 1);
    cmdDestMask = 4'b0010;
    waitCyc(3);
    check("R9 still held", int'(cmdReady), 0);
    txReady = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdDestMask = '0;
    waitCyc(120);
    check("R10 packet count", txN - base, 6);
    for (int i = 0; i < 6; i++) check("R10 order", int'(txLog[base + i]), byteOf(50 + i, 1));
  endtask

  task automatic testStalls();
    int base = txN;
    int r0 = relN;
    int pg [3] = '{60, 0, 0};
    setPage(60, 0, 1, 5);
    @(negedge clk); relReady = 1'b0;
    sendCmd(4'b0010, 60);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); txReady = (i % 3) != 0;
    end
    txReady = 1'b1;
    waitCyc(10);
    checkChain("R11 bytes under stall", base, pg, 1, 5);
    check("R12 pending", int'(relValid), 1);
    check("R12 page", int'(relPage), 60);
    waitCyc(5);
    check("R12 still pending", int'(relValid), 1);
    check("R12 nothing taken", relN - r0, 0);
    relReady = 1'b1;
    waitCyc(3);
    check("R12 taken once", relN - r0, 1);
    check("R12 taken page", relLog[r0], 60);
    check("R12 cleared", int'(relValid), 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFilter();
    testSingle();
    testMultiNotLast();
    testMultiLast();
    testBackPressure();
    testStalls();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule